// File: doc/BRIEF.md
# Single-Channel Eight-Bit PWM Generator

This block produces one pulse-width-modulated waveform from an up counter that steps only on cycles where a prescaled channel tick is present. Two shape modes exist: in edge mode the counter climbs from zero to one below the programmed period and then restarts from zero. In symmetric mode it climbs to the period value and then falls back, so one output period spans twice as many ticks. The output is high while the count is below the programmed duty value. The running count is visible on an output port at all times.

Period and duty values come from registers outside this block. They are copied into internal working copies only at a period boundary, on a counter write, or while the channel is off, so a period never runs with mixed settings. A write strobe clears the counter whatever data goes with it. Switching the channel off freezes the count and forces the output low. Switching it back on continues from the frozen count.

Top module: `pwm_chan_core`

## Requirements
- R1: After reset `cnt_val` is 0 and `pwm_out` is 0.
- R2: A cycle with `cnt_wr` high makes `cnt_val` 0 on the next cycle. This takes precedence over a tick in the same cycle.
- R3: While `chan_on` is 0 the count holds its value. When `chan_on` returns to 1, the next tick advances the count from the held value.
- R4: The count changes only on cycles with `tick_en` high, apart from counter writes.
- R5: While `chan_on` is 0, `pwm_out` is 0.
- R6: With `center_sel` = 0 and period P ≥ 1, the count runs 0..P−1 and wraps, giving a period of P ticks. `pwm_out` is high while count < duty, so it is high for min(duty, P) ticks per period; a duty of 0 keeps it low.
- R7: With `center_sel` = 1 and P ≥ 1, the count runs 0 up to P and back down to 1, then returns to 0, giving a period of 2·P ticks. `pwm_out` is high for 2·duty−1 ticks per period when 1 ≤ duty ≤ P.
- R8: With a working period of 0 and the channel on, `pwm_out` is constantly 1 and the count stays 0.
- R9: A change of `per_reg` or `duty_reg` takes effect only after the current period ends, or at once after a counter write or while the channel is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Prescaled channel tick; the counter steps only when high |
| chan_on | input | 1 | Channel enable |
| center_sel | input | 1 | 0 = edge (up-only) mode, 1 = symmetric (up/down) mode |
| per_reg | input | 8 | Period register value |
| duty_reg | input | 8 | Duty register value |
| cnt_wr | input | 1 | Counter write strobe; clears the count |
| pwm_out | output | 1 | PWM waveform, active high |
| cnt_val | output | 8 | Current counter value |

## Verification
A counter write can arrive in the same cycle as a tick, and also in the same cycle in which that tick would end a period and reload the working copies. The bench raises `cnt_wr` together with `tick_en` while the channel runs and expects a count of zero on the next cycle. In that case the clear wins over both the increment and the wrap. A separate property checks that the working period changes only in cycles where a reload is allowed, which covers write, wrap and disabled reloads landing together.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic {
    ALIGN_EDGE   = 1'b0,
    ALIGN_SYMM   = 1'b1
  } align_e;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] duty_in,
  output logic [W-1:0] per_q,
  output logic [W-1:0] duty_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
    end else if (load) begin
      per_q  <= per_in;
      duty_q <= duty_in;
    end
  end
endmodule

// File: rtl/pwm_ctr.sv
module pwm_ctr
  import pwm_chan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clr,
  input  align_e       mode,
  input  logic [W-1:0] per_act,
  output logic [W-1:0] cnt,
  output logic         period_end
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         dn_q, dn_nxt;
  logic [W-1:0] cnt_nxt;

  // edge mode: last count of a period is per-1
  function automatic logic edge_last(input logic [W-1:0] c, input logic [W-1:0] p);
    return c >= (p - ONE);
  endfunction

  // symmetric mode: turn around at the top
  function automatic logic symm_top(input logic [W-1:0] c, input logic [W-1:0] p);
    return c >= p;
  endfunction

  always_comb begin
    cnt_nxt    = cnt;
    dn_nxt     = dn_q;
    period_end = 1'b0;
    if (clr) begin
      cnt_nxt = '0;
      dn_nxt  = 1'b0;
    end else if (step) begin
      if (per_act == '0) begin
        cnt_nxt    = '0;
        dn_nxt     = 1'b0;
        period_end = 1'b1;
      end else if (mode == ALIGN_EDGE) begin
        dn_nxt = 1'b0;
        if (edge_last(cnt, per_act)) begin
          cnt_nxt    = '0;
          period_end = 1'b1;
        end else begin
          cnt_nxt = cnt + ONE;
        end
      end else if (!dn_q) begin
        if (symm_top(cnt, per_act)) begin
          cnt_nxt    = cnt - ONE;
          dn_nxt     = (cnt_nxt != '0);
          period_end = (cnt_nxt == '0);
        end else begin
          cnt_nxt = cnt + ONE;
        end
      end else begin
        if (cnt <= ONE) begin
          cnt_nxt    = '0;
          dn_nxt     = 1'b0;
          period_end = 1'b1;
        end else begin
          cnt_nxt = cnt - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dn_q <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      dn_q <= dn_nxt;
    end
  end
endmodule

// File: rtl/pwm_cmp.sv
module pwm_cmp #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic [W-1:0] per_act,
  input  logic [W-1:0] duty_act,
  input  logic [W-1:0] cnt,
  output logic         wave
);
  function automatic logic below_duty(input logic [W-1:0] c, input logic [W-1:0] d);
    return c < d;
  endfunction

  always_comb begin
    if (!en)                 wave = 1'b0;
    else if (per_act == '0)  wave = 1'b1;
    else                     wave = below_duty(cnt, duty_act);
  end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_chan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         chan_on,
  input  logic         center_sel,
  input  logic [W-1:0] per_reg,
  input  logic [W-1:0] duty_reg,
  input  logic         cnt_wr,
  output logic         pwm_out,
  output logic [W-1:0] cnt_val
);
  logic [W-1:0] per_act;
  logic [W-1:0] duty_act;
  logic         period_end;
  logic         step;
  logic         reload;
  align_e       mode;

  assign mode   = align_e'(center_sel);
  assign step   = chan_on & tick_en;
  assign reload = !chan_on | cnt_wr | period_end;

  pwm_shadow #(.W(W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (reload),
    .per_in  (per_reg),
    .duty_in (duty_reg),
    .per_q   (per_act),
    .duty_q  (duty_act)
  );

  pwm_ctr #(.W(W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .clr        (cnt_wr),
    .mode       (mode),
    .per_act    (per_act),
    .cnt        (cnt_val),
    .period_end (period_end)
  );

  pwm_cmp #(.W(W)) u_cmp (
    .en       (chan_on),
    .per_act  (per_act),
    .duty_act (duty_act),
    .cnt      (cnt_val),
    .wave     (pwm_out)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         chan_on,
  input logic         cnt_wr,
  input logic         pwm_out,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] per_act,
  input logic         period_end
);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_val == '0);

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_on && !cnt_wr) |=> $stable(cnt_val));

  p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(cnt_val));

  p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_on |-> !pwm_out);

  p_unit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && tick_en && !cnt_wr) |=>
      (cnt_val == W'($past(cnt_val) + 1'b1)) ||
      (cnt_val == W'($past(cnt_val) - 1'b1)) ||
      (cnt_val == '0));

  p_zero_per_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && per_act == '0) |-> pwm_out);

  p_reload_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && !cnt_wr && !period_end) |=> $stable(per_act));
endmodule

bind pwm_chan_core pwm_chan_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .chan_on    (chan_on),
  .cnt_wr     (cnt_wr),
  .pwm_out    (pwm_out),
  .cnt_val    (cnt_val),
  .per_act    (per_act),
  .period_end (period_end)
);

// File: tb/sim_pwm_chan_core.sv
`timescale 1ns/1ps
module sim_pwm_chan_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       chan_on = 1'b0;
  logic       center_sel = 1'b0;
  logic [7:0] per_reg = '0;
  logic [7:0] duty_reg = '0;
  logic       cnt_wr = 1'b0;
  logic       pwm_out;
  logic [7:0] cnt_val;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwm_chan_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .chan_on(chan_on),
    .center_sel(center_sel), .per_reg(per_reg), .duty_reg(duty_reg),
    .cnt_wr(cnt_wr), .pwm_out(pwm_out), .cnt_val(cnt_val)
  );

  // {center, period, duty}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'd10,  8'd3},
    {1'b0, 8'd16,  8'd1},
    {1'b0, 8'd200, 8'd150},
    {1'b0, 8'd2,   8'd1},
    {1'b1, 8'd10,  8'd3},
    {1'b1, 8'd4,   8'd4},
    {1'b1, 8'd1,   8'd1}
  };

  function automatic int exp_period(input bit c, input int p);
    return c ? 2 * p : p;
  endfunction

  function automatic int exp_high(input bit c, input int p, input int d);
    if (!c) return (d < p) ? d : p;
    return (d > p) ? 2 * p : 2 * d - 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_chan(input bit c, input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    chan_on = 1'b0; center_sel = c; per_reg = p; duty_reg = d; tick_en = 1'b1;
    @(negedge clk);
    cnt_wr = 1'b1; chan_on = 1'b1;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic measure(output int per_m, output int hi_m);
    bit prev;
    int guard;
    prev = 1'b1;
    guard = 0;
    while (!(!prev && pwm_out) && guard < 2000) begin
      prev = pwm_out;
      @(negedge clk);
      guard++;
    end
    per_m = 0; hi_m = 0;
    do begin
      hi_m += int'(pwm_out);
      per_m++;
      prev = pwm_out;
      @(negedge clk);
    end while (!(!prev && pwm_out) && per_m < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int pm, hm, guard;
    repeat (3) @(negedge clk);
    check("R1 count after reset", int'(cnt_val), 0);
    check("R1 output after reset", int'(pwm_out), 0);
    rst_n = 1'b1;

    // table of period and duty measurements, R6 and R7
    for (int i = 0; i < NV; i++) begin
      start_chan(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
      measure(pm, hm);
      check(VEC[i][16] ? "R7 period" : "R6 period", pm,
            exp_period(VEC[i][16], int'(VEC[i][15:8])));
      check(VEC[i][16] ? "R7 high time" : "R6 high time", hm,
            exp_high(VEC[i][16], int'(VEC[i][15:8]), int'(VEC[i][7:0])));
    end

    // counting, freeze, resume, tick gating, write clear
    start_chan(1'b0, 8'd20, 8'd10);
    check("R2 clear on write", int'(cnt_val), 0);
    repeat (5) @(negedge clk);
    check("R4 counts with ticks", int'(cnt_val), 5);
    chan_on = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 frozen while off", int'(cnt_val), 5);
    check("R5 low while off", int'(pwm_out), 0);
    chan_on = 1'b1;
    @(negedge clk);
    check("R3 resume from held count", int'(cnt_val), 6);
    tick_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 hold without tick", int'(cnt_val), 6);
    tick_en = 1'b1; cnt_wr = 1'b1;
    @(negedge clk);
    cnt_wr = 1'b0;
    check("R2 write beats tick", int'(cnt_val), 0);

    // zero period
    start_chan(1'b0, 8'd0, 8'd5);
    repeat (6) @(negedge clk);
    check("R8 constant high", int'(pwm_out), 1);
    check("R8 count pinned", int'(cnt_val), 0);

    // zero duty keeps the output low over a whole period
    start_chan(1'b0, 8'd8, 8'd0);
    hm = 0;
    for (int k = 0; k < 16; k++) begin
      hm += int'(pwm_out);
      @(negedge clk);
    end
    check("R6 duty zero low", hm, 0);

    // duty change mid-period waits for the wrap
    start_chan(1'b0, 8'd10, 8'd3);
    guard = 0;
    while (cnt_val != 8'd5 && guard < 100) begin @(negedge clk); guard++; end
    duty_reg = 8'd8;
    @(negedge clk);
    check("R9 old duty kept in period", int'(pwm_out), 0);
    guard = 0;
    while (cnt_val != 8'd0 && guard < 100) begin @(negedge clk); guard++; end
    guard = 0;
    while (cnt_val != 8'd6 && guard < 100) begin @(negedge clk); guard++; end
    check("R9 new duty after wrap", int'(pwm_out), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule